// File: doc/BRIEF.md
# Serial Receive Interrupt Control Register

This block is one byte-wide control and status register that connects the receive interrupt of a single serial controller to a CPU. Software writes it to choose a request priority, to enable the source, to pick how the interrupt vector is produced, and to set two cache-snoop control values. While the controller's interrupt input is high and the source is enabled, the block presents the programmed priority to the system interrupt encoder. The status bit follows the input level, so software never clears it.

When the CPU acknowledges an interrupt at the programmed level, the block claims the cycle. It then returns one of two vectors. In local mode it returns a constant vector built from a base value and a source number. In forwarding mode it strobes the controller's acknowledge line, waits for the controller to signal ready, and passes the controller's vector byte on to the CPU. While the controller owns the bus for DMA, the block drives the two snoop outputs from the register. Otherwise it releases them.

Top module: `rx_irq_ctl`

## Requirements
- R1: After reset every writable field is 0. With the interrupt input low, `reg_rdata` reads 0x00, `ipl_req` is 0, `snoop_oe` is 0 and no acknowledge is claimed.
- R2: A write with `reg_we` high updates bits 7,6 (snoop 1, snoop 0), bit 4 (enable), bit 3 (local-vector select) and bits 2:0 (level), and the new value reads back on the next clock. Bit 5 cannot be written.
- R3: Read bit 5 returns the live status, which is the interrupt input ANDed with the enable bit.
- R4: While the status is high and the level is nonzero, `ipl_req` equals the programmed level. Otherwise it is 0.
- R5: Level 0 never raises a request, even while the status is high.
- R6: The status and the request drop when the input goes low or when the enable is cleared. They come back when the condition returns, with no clearing step.
- R7: An acknowledge pulse is claimed only when `iack_lvl` equals a nonzero programmed level and the status is high. Otherwise `iack_claim`, `iack_done` and `per_iack` all stay low.
- R8: With bit 3 set, a claimed acknowledge gives `iack_done` for one cycle in the clock after the pulse, with `iack_vec` = 0x55 at default parameters. The upper nibble comes from the base value 0x5 and the lower nibble is source number 5.
- R9: With bit 3 clear, `per_iack` goes high from the clock after the pulse until `per_rdy` is sampled high. In the next cycle `iack_done` pulses for one cycle and `iack_vec` carries the `per_vec` byte sampled together with `per_rdy`.
- R10: While `dma_act` is high, `snoop_oe` is 1, `snoop_out[1]` equals bit 7 and `snoop_out[0]` equals bit 6.
- R11: While `dma_act` is low, `snoop_oe` is 0 and `snoop_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, with live status in bit 5 |
| per_irq | input | 1 | Receive interrupt from the serial controller, active high |
| ipl_req | output | 3 | Priority level requested from the interrupt encoder, 0 when idle |
| iack_req | input | 1 | One-cycle acknowledge pulse from the CPU |
| iack_lvl | input | 3 | Level being acknowledged |
| iack_claim | output | 1 | Block is serving the acknowledge |
| iack_done | output | 1 | Vector valid on `iack_vec` |
| iack_vec | output | 8 | Returned interrupt vector |
| per_iack | output | 1 | Acknowledge strobe to the serial controller |
| per_rdy | input | 1 | Controller vector ready |
| per_vec | input | 8 | Vector byte from the controller |
| dma_act | input | 1 | Controller DMA cycle in progress |
| snoop_out | output | 2 | Snoop control values |
| snoop_oe | output | 1 | Output enable for the snoop pins |

## Verification
The bench tries to write the read-only status bit and then reads it back. A design that latched it would show a status with no live interrupt behind it. Between pulses of the interrupt input it checks that status and request return without any clear step, and that level 0 stays silent even while the status is high. An edge-latched or ungated request would fail one of these. It presents acknowledges at a wrong level and with the status low, where a design that skips the level compare would claim the cycle or strobe the controller. It holds `per_rdy` low for several cycles in forwarding mode, to catch a design that returns a vector before the handshake ends or that loses the sampled byte.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;

    localparam int CSR_W  = 8;
    localparam int LVL_W  = 3;
    localparam int B_SNP1 = 7;
    localparam int B_SNP0 = 6;
    localparam int B_STS  = 5;
    localparam int B_IEN  = 4;
    localparam int B_LOC  = 3;

    typedef struct packed {
        logic [1:0]       snoop;
        logic             ien;
        logic             loc_vec;
        logic [LVL_W-1:0] lvl;
    } ctl_t;

    typedef enum logic [1:0] {
        AK_IDLE  = 2'd0,
        AK_LOCAL = 2'd1,
        AK_FETCH = 2'd2,
        AK_RESP  = 2'd3
    } ack_st_t;

    function automatic ctl_t csr_unpack(input logic [CSR_W-1:0] b);
        ctl_t c;
        c.snoop   = {b[B_SNP1], b[B_SNP0]};
        c.ien     = b[B_IEN];
        c.loc_vec = b[B_LOC];
        c.lvl     = b[LVL_W-1:0];
        return c;
    endfunction

    function automatic logic [CSR_W-1:0] csr_pack(input ctl_t c, input logic sts);
        logic [CSR_W-1:0] b;
        b              = '0;
        b[B_SNP1]      = c.snoop[1];
        b[B_SNP0]      = c.snoop[0];
        b[B_STS]       = sts;
        b[B_IEN]       = c.ien;
        b[B_LOC]       = c.loc_vec;
        b[LVL_W-1:0]   = c.lvl;
        return b;
    endfunction

endpackage

// File: rtl/rxirq_csr.sv
module rxirq_csr
    import rxirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CSR_W-1:0] wdata,
    input  logic             sts,
    output ctl_t             ctl,
    output logic [CSR_W-1:0] rdata
);
    ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (we) begin
            ctl_q <= csr_unpack(wdata);
        end
    end

    assign ctl   = ctl_q;
    assign rdata = csr_pack(ctl_q, sts);
endmodule

// File: rtl/rxirq_req.sv
module rxirq_req
    import rxirq_pkg::*;
(
    input  ctl_t             ctl,
    input  logic             per_irq,
    output logic             sts,
    output logic [LVL_W-1:0] ipl_req
);
    always_comb begin
        sts     = per_irq & ctl.ien;
        ipl_req = '0;
        if (sts && (ctl.lvl != '0)) begin
            ipl_req = ctl.lvl;
        end
    end
endmodule

// File: rtl/rxirq_ack.sv
module rxirq_ack
    import rxirq_pkg::*;
#(
    parameter int              DW       = 8,
    parameter int              ID_W     = 4,
    parameter logic [DW-1:0]   VEC_BASE = 8'h50,
    parameter logic [ID_W-1:0] SRC_ID   = 4'h5
) (
    input  logic             clk,
    input  logic             rst,
    input  ctl_t             ctl,
    input  logic             sts,
    input  logic             iack_req,
    input  logic [LVL_W-1:0] iack_lvl,
    input  logic             per_rdy,
    input  logic [DW-1:0]    per_vec,
    output logic             claim,
    output logic             done,
    output logic [DW-1:0]    vec,
    output logic             per_iack
);
    localparam logic [DW-1:0] LOC_VEC = {VEC_BASE[DW-1:ID_W], SRC_ID};

    ack_st_t       st;
    logic [DW-1:0] vec_q;
    logic          hit;

    assign hit = iack_req && sts && (ctl.lvl != '0) && (iack_lvl == ctl.lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= AK_IDLE;
            vec_q <= '0;
        end else begin
            unique case (st)
                AK_IDLE: begin
                    if (hit) begin
                        st <= ctl.loc_vec ? AK_LOCAL : AK_FETCH;
                    end
                end
                AK_LOCAL: st <= AK_IDLE;
                AK_FETCH: begin
                    if (per_rdy) begin
                        vec_q <= per_vec;
                        st    <= AK_RESP;
                    end
                end
                AK_RESP: st <= AK_IDLE;
                default: st <= AK_IDLE;
            endcase
        end
    end

    always_comb begin
        claim    = (st != AK_IDLE);
        done     = (st == AK_LOCAL) || (st == AK_RESP);
        per_iack = (st == AK_FETCH);
        vec      = '0;
        if (st == AK_LOCAL) begin
            vec = LOC_VEC;
        end else if (st == AK_RESP) begin
            vec = vec_q;
        end
    end
endmodule

// File: rtl/rx_irq_ctl.sv
module rx_irq_ctl
    import rxirq_pkg::*;
#(
    parameter int              DW       = 8,
    parameter int              ID_W     = 4,
    parameter logic [DW-1:0]   VEC_BASE = 8'h50,
    parameter logic [ID_W-1:0] SRC_ID   = 4'h5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [CSR_W-1:0] reg_wdata,
    output logic [CSR_W-1:0] reg_rdata,
    input  logic             per_irq,
    output logic [LVL_W-1:0] ipl_req,
    input  logic             iack_req,
    input  logic [LVL_W-1:0] iack_lvl,
    output logic             iack_claim,
    output logic             iack_done,
    output logic [DW-1:0]    iack_vec,
    output logic             per_iack,
    input  logic             per_rdy,
    input  logic [DW-1:0]    per_vec,
    input  logic             dma_act,
    output logic [1:0]       snoop_out,
    output logic             snoop_oe
);
    ctl_t ctl;
    logic sts;

    rxirq_csr u_csr (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .wdata (reg_wdata),
        .sts   (sts),
        .ctl   (ctl),
        .rdata (reg_rdata)
    );

    rxirq_req u_req (
        .ctl     (ctl),
        .per_irq (per_irq),
        .sts     (sts),
        .ipl_req (ipl_req)
    );

    rxirq_ack #(
        .DW       (DW),
        .ID_W     (ID_W),
        .VEC_BASE (VEC_BASE),
        .SRC_ID   (SRC_ID)
    ) u_ack (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .sts      (sts),
        .iack_req (iack_req),
        .iack_lvl (iack_lvl),
        .per_rdy  (per_rdy),
        .per_vec  (per_vec),
        .claim    (iack_claim),
        .done     (iack_done),
        .vec      (iack_vec),
        .per_iack (per_iack)
    );

    assign snoop_oe = dma_act;

    for (genvar i = 0; i < 2; i++) begin : g_snp
        assign snoop_out[i] = dma_act & ctl.snoop[i];
    end
endmodule

// File: rtl/rx_irq_ctl_chk.sv
module rx_irq_ctl_chk
    import rxirq_pkg::*;
#(
    parameter int DW = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_we,
    input logic [CSR_W-1:0] reg_wdata,
    input logic [CSR_W-1:0] reg_rdata,
    input logic             per_irq,
    input logic [LVL_W-1:0] ipl_req,
    input logic             iack_claim,
    input logic             iack_done,
    input logic             per_iack,
    input logic             dma_act,
    input logic [1:0]       snoop_out,
    input logic             snoop_oe
);
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> (reg_rdata[7:6] == $past(reg_wdata[7:6])) &&
                   (reg_rdata[4:0] == $past(reg_wdata[4:0]))); // R2

    AST_STATUS_LIVE: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[B_STS] == (per_irq && reg_rdata[B_IEN])); // R3

    AST_REQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (ipl_req != 0) |-> (ipl_req == reg_rdata[2:0]) && reg_rdata[B_STS]); // R4

    AST_LVL0_QUIET: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[2:0] == 0) |-> (ipl_req == 0)); // R5

    AST_DONE_CLAIMED: assert property (@(posedge clk) disable iff (rst)
        iack_done |-> iack_claim && !per_iack); // R7

    AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
        iack_done |=> !iack_done); // R8

    AST_SNOOP_DRIVE: assert property (@(posedge clk) disable iff (rst)
        dma_act |-> snoop_oe && (snoop_out == reg_rdata[7:6])); // R10

    AST_SNOOP_FREE: assert property (@(posedge clk) disable iff (rst)
        !dma_act |-> !snoop_oe && (snoop_out == 2'b00)); // R11
endmodule

bind rx_irq_ctl rx_irq_ctl_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_rx_irq_ctl.sv
module sim_rx_irq_ctl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       per_irq = 1'b0;
    logic [2:0] ipl_req;
    logic       iack_req = 1'b0;
    logic [2:0] iack_lvl = '0;
    logic       iack_claim, iack_done, per_iack;
    logic [7:0] iack_vec;
    logic       per_rdy = 1'b0;
    logic [7:0] per_vec = '0;
    logic       dma_act = 1'b0;
    logic [1:0] snoop_out;
    logic       snoop_oe;

    int nvec = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    rx_irq_ctl u0 (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        #1;
    endtask

    task automatic pulse_iack(input logic [2:0] l);
        @(negedge clk);
        iack_req = 1'b1; iack_lvl = l;
        @(negedge clk);
        iack_req = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 ipl", {5'd0, ipl_req}, 8'h00);
        chk("R1 oe/claim", {6'd0, snoop_oe, iack_claim}, 8'h00);
    endtask

    task automatic t_regs;
        per_irq = 1'b0;
        wr(8'hFF);
        chk("R2 readback", reg_rdata, 8'hDF);
        per_irq = 1'b1; step();
        chk("R3 live status", reg_rdata, 8'hFF);
        wr(8'h20);
        chk("R2 bit5 not writable", reg_rdata, 8'h00);
        wr(8'h10);
        chk("R3 status with enable", reg_rdata, 8'h30);
        per_irq = 1'b0; step();
        wr(8'h00);
    endtask

    task automatic t_req;
        wr(8'h15);
        per_irq = 1'b1; step();
        chk("R4 level 5", {5'd0, ipl_req}, 8'h05);
        per_irq = 1'b0; step();
        chk("R6 drop on input", {reg_rdata[5], 4'd0, ipl_req}, 8'h00);
        per_irq = 1'b1; step();
        chk("R6 returns no clear", {5'd0, ipl_req}, 8'h05);
        wr(8'h05);
        chk("R6 drop on enable", {reg_rdata[5], 4'd0, ipl_req}, 8'h00);
        wr(8'h10);
        chk("R5 level0 quiet", {reg_rdata[5], 4'd0, ipl_req}, 8'h80);
        wr(8'h17);
        chk("R4 level 7", {5'd0, ipl_req}, 8'h07);
    endtask

    task automatic t_iack_local;
        per_irq = 1'b1;
        wr(8'h1B);
        pulse_iack(3'd3);
        chk("R8 done+claim", {5'd0, iack_done, iack_claim, per_iack}, 8'h06);
        chk("R8 local vector", iack_vec, 8'h55);
        step();
        chk("R8 single cycle", {6'd0, iack_done, iack_claim}, 8'h00);
    endtask

    task automatic t_iack_miss;
        logic seen;
        seen = 1'b0;
        wr(8'h13);
        pulse_iack(3'd2);
        for (int i = 0; i < 3; i++) begin
            seen = seen | iack_claim | iack_done | per_iack;
            step();
        end
        chk("R7 wrong level", {7'd0, seen}, 8'h00);
        per_irq = 1'b0;
        pulse_iack(3'd3);
        seen = 1'b0;
        for (int i = 0; i < 3; i++) begin
            seen = seen | iack_claim | iack_done | per_iack;
            step();
        end
        chk("R7 status low", {7'd0, seen}, 8'h00);
        per_irq = 1'b1;
    endtask

    task automatic t_iack_pass;
        logic bad;
        bad = 1'b0;
        per_irq = 1'b1;
        wr(8'h13);
        pulse_iack(3'd3);
        for (int i = 0; i < 3; i++) begin
            if (!per_iack || iack_done) bad = 1'b1;
            step();
        end
        chk("R9 strobe held waiting", {7'd0, bad}, 8'h00);
        @(negedge clk);
        per_rdy = 1'b1; per_vec = 8'hA7;
        @(negedge clk);
        per_rdy = 1'b0; per_vec = 8'h00;
        #1;
        chk("R9 done after ready", {5'd0, iack_done, iack_claim, per_iack}, 8'h06);
        chk("R9 forwarded vector", iack_vec, 8'hA7);
        step();
        chk("R9 back idle", {6'd0, iack_done, iack_claim}, 8'h00);
    endtask

    task automatic t_snoop;
        wr(8'h80);
        dma_act = 1'b0; step();
        chk("R11 released", {5'd0, snoop_oe, snoop_out}, 8'h00);
        dma_act = 1'b1; step();
        chk("R10 drive 10", {5'd0, snoop_oe, snoop_out}, 8'h06);
        wr(8'h40);
        chk("R10 drive 01", {5'd0, snoop_oe, snoop_out}, 8'h05);
        wr(8'hC0);
        chk("R10 drive 11", {5'd0, snoop_oe, snoop_out}, 8'h07);
        dma_act = 1'b0; step();
        chk("R11 released again", {5'd0, snoop_oe, snoop_out}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_regs();
        t_req();
        t_iack_local();
        t_iack_miss();
        t_iack_pass();
        t_snoop();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule